// File: doc/BRIEF.md
# Paged Address Translation and Access Guard

This block turns a 14-bit logical address into a 15-bit physical address through a small page table that it holds itself. The upper three address bits select one of eight table entries. The eleven lower bits pass through unchanged as the offset. Each entry stores a 4-bit frame number, a presence flag and three independent permission flags for read, write and execute.

In the same cycle as the frame lookup, the unit checks three things: that the page number is below a programmable table length, that the entry is present, and that the requested kind of access is permitted. When any check fails, the unit raises a trap with a prioritised cause code and suppresses the physical address. Table entries and the length value are loaded through a synchronous configuration write port.

A request strobe captures one access. Its result, together with a single-cycle done pulse, appears on the registered outputs one clock later.

Top module: `pgx_guard`

## Requirements
- R1: While reset (`rst_n` low) is active, every presence flag is cleared and the table length is set to zero. After reset, all outputs are low, and any access traps with cause 2'b01 until a length is written.
- R2: For an access that passes all checks, `rsp_ok`=1, `rsp_trap`=0, `rsp_cause`=2'b00 and `rsp_paddr` = {frame, addr[10:0]}. The page number is addr[13:11].
- R3: An access whose page number is greater than or equal to the table length traps with cause 2'b01, even when the entry is present and permits the access.
- R4: An access within the length to an entry whose presence flag is clear traps with cause 2'b10.
- R5: An access kind whose permission flag is clear traps with cause 2'b11. The kind encodings are read 2'b00, write 2'b01 and execute 2'b10. Kind 2'b11 is reserved and always traps with cause 2'b11.
- R6: The permission flags act independently. A read-only entry (r=1, w=0, x=0) allows only reads. An execute-only entry (x=1, r=0, w=0) allows only execution.
- R7: Cause priority is fixed: length (2'b01) wins over absent (2'b10), which wins over permission (2'b11).
- R8: Whenever `rsp_trap` is 1, `rsp_paddr` is zero, `rsp_ok` is 0 and `rsp_cause` is non-zero.
- R9: Results appear on the clock edge after the edge that samples `req_valid`=1. `rsp_done` is high for exactly that one cycle per strobe, and it stays low when no strobe is given.
- R10: Configuration writes use `cfg_data` = {v, r, w, x, frame[3:0]} when `cfg_len`=0. When `cfg_len`=1, the length is taken from `cfg_data[3:0]`. A request sampled on the same edge as a write uses the table contents from before the write.
- R11: A length of 8 admits page 7. A length of N admits exactly the pages 0 to N-1.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_len | input | 1 | 1: write the table length, 0: write the entry at cfg_idx |
| cfg_idx | input | 3 | Entry index for an entry write |
| cfg_data | input | 8 | Entry {v,r,w,x,frame} or length in bits [3:0] |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 14 | Logical address |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| rsp_done | output | 1 | One-cycle result pulse |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_paddr | output | 15 | Physical address, zero on a trap |
| rsp_trap | output | 1 | Access trapped |
| rsp_cause | output | 2 | 00 none, 01 length, 10 absent, 11 permission |

## Verification
A configuration write and a translation request can be sampled on the same clock edge. This is the case where table contents and the lookup collide. The bench provokes it by strobing both in the same cycle: it rewrites an absent entry as present and reads that same page. The first result must still show the absent-page trap from the old contents, and a repeated request must then translate through the new frame. Combined failures, such as an absent page beyond the length or an absent entry that carries permissions, are used to judge the cause priority.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

   typedef enum logic [1:0] {
      ACC_RD  = 2'b00,
      ACC_WR  = 2'b01,
      ACC_EX  = 2'b10,
      ACC_RSV = 2'b11
   } acc_e;

   typedef enum logic [1:0] {
      TRAP_NONE = 2'b00,
      TRAP_LEN  = 2'b01,
      TRAP_ABS  = 2'b10,
      TRAP_PERM = 2'b11
   } trap_e;

   // flag nibble sits directly above the frame field in an entry
   localparam int unsigned FLG_X   = 0;
   localparam int unsigned FLG_W   = 1;
   localparam int unsigned FLG_R   = 2;
   localparam int unsigned FLG_V   = 3;
   localparam int unsigned FLG_CNT = 4;

endpackage

// File: rtl/pgx_table.sv
module pgx_table
   import pgx_pkg::*;
#(
   parameter int unsigned PN_W        = 3,
   parameter int unsigned FRAME_W     = 4,
   parameter bit          KEEP_BODIES = 1'b0,
   localparam int unsigned ENTRIES    = 1 << PN_W,
   localparam int unsigned ENTRY_W    = FRAME_W + FLG_CNT
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_len,
   input  logic [PN_W-1:0]    wr_idx,
   input  logic [ENTRY_W-1:0] wr_data,
   input  logic [PN_W-1:0]    rd_idx,
   output logic               rd_vld,
   output logic [2:0]         rd_perm,
   output logic [FRAME_W-1:0] rd_frame,
   output logic [PN_W:0]      len_q
);

   localparam int unsigned BODY_W = FRAME_W + 3;

   logic [ENTRIES-1:0] vld_q;
   logic [BODY_W-1:0]  body_q [ENTRIES];

   // length register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         len_q <= '0;
      else if (wr_en && wr_len)
         len_q <= wr_data[PN_W:0];
   end

   for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_ent
      logic hit;
      assign hit = wr_en && !wr_len && (wr_idx == PN_W'(gi));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            vld_q[gi] <= 1'b0;
         else if (hit)
            vld_q[gi] <= wr_data[FRAME_W + FLG_V];
      end

      if (KEEP_BODIES) begin : g_keep
         always_ff @(posedge clk) begin
            if (hit)
               body_q[gi] <= wr_data[BODY_W-1:0];
         end
      end else begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               body_q[gi] <= '0;
            else if (hit)
               body_q[gi] <= wr_data[BODY_W-1:0];
         end
      end
   end

   logic [BODY_W-1:0] rd_body;
   assign rd_body  = body_q[rd_idx];
   assign rd_vld   = vld_q[rd_idx];
   assign rd_frame = rd_body[FRAME_W-1:0];
   assign rd_perm  = {rd_body[FRAME_W + FLG_R],
                      rd_body[FRAME_W + FLG_W],
                      rd_body[FRAME_W + FLG_X]};

endmodule

// File: rtl/pgx_check.sv
module pgx_check
   import pgx_pkg::*;
#(
   parameter int unsigned PN_W    = 3,
   parameter int unsigned OFF_W   = 11,
   parameter int unsigned FRAME_W = 4,
   localparam int unsigned PA_W   = FRAME_W + OFF_W
)(
   input  logic [PN_W-1:0]    page,
   input  logic [OFF_W-1:0]   offset,
   input  logic [1:0]         kind,
   input  logic               ent_vld,
   input  logic [2:0]         ent_perm,
   input  logic [FRAME_W-1:0] ent_frame,
   input  logic [PN_W:0]      len,
   output logic               ok,
   output logic [1:0]         cause,
   output logic [PA_W-1:0]    paddr
);

   logic beyond;
   logic allowed;

   assign beyond = ({1'b0, page} >= len);

   always_comb begin
      unique case (kind)
         ACC_RD:  allowed = ent_perm[2];
         ACC_WR:  allowed = ent_perm[1];
         ACC_EX:  allowed = ent_perm[0];
         default: allowed = 1'b0;
      endcase
   end

   always_comb begin
      if (beyond)
         cause = TRAP_LEN;
      else if (!ent_vld)
         cause = TRAP_ABS;
      else if (!allowed)
         cause = TRAP_PERM;
      else
         cause = TRAP_NONE;
   end

   assign ok    = (cause == TRAP_NONE);
   assign paddr = ok ? {ent_frame, offset} : '0;

endmodule

// File: rtl/pgx_resp.sv
module pgx_resp #(
   parameter int unsigned PA_W = 15
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fire,
   input  logic            ok_d,
   input  logic [1:0]      cause_d,
   input  logic [PA_W-1:0] paddr_d,
   output logic            done_q,
   output logic            ok_q,
   output logic            trap_q,
   output logic [1:0]      cause_q,
   output logic [PA_W-1:0] paddr_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         ok_q    <= 1'b0;
         trap_q  <= 1'b0;
         cause_q <= '0;
         paddr_q <= '0;
      end else begin
         done_q <= fire;
         if (fire) begin
            ok_q    <= ok_d;
            trap_q  <= !ok_d;
            cause_q <= cause_d;
            paddr_q <= paddr_d;
         end
      end
   end

endmodule

// File: rtl/pgx_guard.sv
module pgx_guard
   import pgx_pkg::*;
#(
   parameter int unsigned LA_W        = 14,
   parameter int unsigned OFF_W       = 11,
   parameter int unsigned FRAME_W     = 4,
   parameter bit          KEEP_BODIES = 1'b0,
   localparam int unsigned PN_W       = LA_W - OFF_W,
   localparam int unsigned PA_W       = FRAME_W + OFF_W,
   localparam int unsigned ENTRY_W    = FRAME_W + FLG_CNT
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic               cfg_len,
   input  logic [PN_W-1:0]    cfg_idx,
   input  logic [ENTRY_W-1:0] cfg_data,
   input  logic               req_valid,
   input  logic [LA_W-1:0]    req_addr,
   input  logic [1:0]         req_kind,
   output logic               rsp_done,
   output logic               rsp_ok,
   output logic [PA_W-1:0]    rsp_paddr,
   output logic               rsp_trap,
   output logic [1:0]         rsp_cause
);

   if (OFF_W < 1 || OFF_W >= LA_W) begin : g_bad_off
      $error("pgx_guard: OFF_W must lie between 1 and LA_W-1");
   end
   if (PN_W > 8) begin : g_bad_pn
      $error("pgx_guard: page table too large for a flop table");
   end
   if (PN_W + 1 > ENTRY_W) begin : g_bad_len
      $error("pgx_guard: length value does not fit the config word");
   end
   if (FRAME_W < 1) begin : g_bad_frame
      $error("pgx_guard: FRAME_W must be at least 1");
   end

   logic [PN_W-1:0]    page;
   logic [OFF_W-1:0]   offset;
   logic               ent_vld;
   logic [2:0]         ent_perm;
   logic [FRAME_W-1:0] ent_frame;
   logic [PN_W:0]      len_q;
   logic               chk_ok;
   logic [1:0]         chk_cause;
   logic [PA_W-1:0]    chk_paddr;

   assign page   = req_addr[LA_W-1:OFF_W];
   assign offset = req_addr[OFF_W-1:0];

   pgx_table #(
      .PN_W        (PN_W),
      .FRAME_W     (FRAME_W),
      .KEEP_BODIES (KEEP_BODIES)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_len   (cfg_len),
      .wr_idx   (cfg_idx),
      .wr_data  (cfg_data),
      .rd_idx   (page),
      .rd_vld   (ent_vld),
      .rd_perm  (ent_perm),
      .rd_frame (ent_frame),
      .len_q    (len_q)
   );

   pgx_check #(
      .PN_W    (PN_W),
      .OFF_W   (OFF_W),
      .FRAME_W (FRAME_W)
   ) u_check (
      .page      (page),
      .offset    (offset),
      .kind      (req_kind),
      .ent_vld   (ent_vld),
      .ent_perm  (ent_perm),
      .ent_frame (ent_frame),
      .len       (len_q),
      .ok        (chk_ok),
      .cause     (chk_cause),
      .paddr     (chk_paddr)
   );

   pgx_resp #(
      .PA_W (PA_W)
   ) u_resp (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (req_valid),
      .ok_d    (chk_ok),
      .cause_d (chk_cause),
      .paddr_d (chk_paddr),
      .done_q  (rsp_done),
      .ok_q    (rsp_ok),
      .trap_q  (rsp_trap),
      .cause_q (rsp_cause),
      .paddr_q (rsp_paddr)
   );

endmodule

// File: rtl/pgx_guard_chk.sv
module pgx_guard_chk #(
   parameter int unsigned LA_W    = 14,
   parameter int unsigned OFF_W   = 11,
   parameter int unsigned FRAME_W = 4,
   localparam int unsigned PA_W   = FRAME_W + OFF_W
)(
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_we,
   input logic            cfg_len,
   input logic            req_valid,
   input logic [LA_W-1:0] req_addr,
   input logic            rsp_done,
   input logic            rsp_ok,
   input logic [PA_W-1:0] rsp_paddr,
   input logic            rsp_trap,
   input logic [1:0]      rsp_cause
);

   logic len_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         len_seen <= 1'b0;
      else if (cfg_we && cfg_len)
         len_seen <= 1'b1;
   end

   // R1: until a length is written, every access traps on length
   p_unconfigured_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !len_seen) |=> (rsp_trap && rsp_cause == 2'b01));

   // R2: a good translation keeps the offset bits
   p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (!rsp_ok || rsp_paddr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0])));

   // R8: a trap suppresses the address and carries a cause
   p_trap_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_trap |-> (rsp_paddr == '0 && !rsp_ok && rsp_cause != 2'b00));

   // R9: done follows a strobe by exactly one cycle
   p_done_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_done);

   p_no_spurious_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_done);

   // R2: ok and trap are exclusive once a result is out
   p_ok_xor_trap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (rsp_ok != rsp_trap));

endmodule

bind pgx_guard pgx_guard_chk #(
   .LA_W    (LA_W),
   .OFF_W   (OFF_W),
   .FRAME_W (FRAME_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_len   (cfg_len),
   .req_valid (req_valid),
   .req_addr  (req_addr),
   .rsp_done  (rsp_done),
   .rsp_ok    (rsp_ok),
   .rsp_paddr (rsp_paddr),
   .rsp_trap  (rsp_trap),
   .rsp_cause (rsp_cause)
);

// File: tb/test_pgx_guard.sv
`timescale 1ns/1ps
module test_pgx_guard;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_len = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic [7:0]  cfg_data = '0;
   logic        req_valid = 1'b0;
   logic [13:0] req_addr = '0;
   logic [1:0]  req_kind = '0;
   logic        rsp_done, rsp_ok, rsp_trap;
   logic [14:0] rsp_paddr;
   logic [1:0]  rsp_cause;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   pgx_guard i_pgx_guard (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_len(cfg_len), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
      .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind),
      .rsp_done(rsp_done), .rsp_ok(rsp_ok), .rsp_paddr(rsp_paddr),
      .rsp_trap(rsp_trap), .rsp_cause(rsp_cause)
   );

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic write_entry(logic [2:0] idx, logic [7:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_len = 1'b0; cfg_idx = idx; cfg_data = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic write_length(logic [3:0] n);
      @(negedge clk);
      cfg_we = 1'b1; cfg_len = 1'b1; cfg_data = {4'h0, n};
      @(negedge clk);
      cfg_we = 1'b0; cfg_len = 1'b0;
   endtask

   // one strobe, result sampled on the following falling edge
   task automatic access(string tag, logic [13:0] a, logic [1:0] k,
                         logic exp_ok, logic [1:0] exp_cause, logic [14:0] exp_pa);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_kind = k;
      @(negedge clk);
      req_valid = 1'b0;
      check({tag, " done"},  {31'b0, rsp_done}, 32'd1);
      check({tag, " ok"},    {31'b0, rsp_ok}, {31'b0, exp_ok});
      check({tag, " trap"},  {31'b0, rsp_trap}, {31'b0, !exp_ok});
      check({tag, " cause"}, {30'b0, rsp_cause}, {30'b0, exp_cause});
      check({tag, " paddr"}, {17'b0, rsp_paddr}, {17'b0, exp_pa});
   endtask

   task automatic t_reset;
      check("R1 done at reset",  {31'b0, rsp_done}, 32'd0);
      check("R1 trap at reset",  {31'b0, rsp_trap}, 32'd0);
      check("R1 paddr at reset", {17'b0, rsp_paddr}, 32'd0);
      access("R1 unconfigured read", 14'h0000, 2'b00, 1'b0, 2'b01, 15'h0);
      write_entry(3'd0, 8'hF5);
      access("R1 entry but length zero", 14'h0010, 2'b00, 1'b0, 2'b01, 15'h0);
   endtask

   task automatic t_setup;
      write_entry(3'd0, 8'hF5); // v r w x, frame 5
      write_entry(3'd1, 8'hC9); // read-only, frame 9
      write_entry(3'd2, 8'h93); // execute-only, frame 3
      write_entry(3'd3, 8'h72); // absent with rwx, frame 2
      write_entry(3'd4, 8'h8A); // present, no permission, frame A
      write_entry(3'd7, 8'hFF); // rwx, frame F
      write_length(4'd5);
   endtask

   task automatic t_translate;
      access("R2 read page0",  14'h0123, 2'b00, 1'b1, 2'b00, 15'h2923);
      access("R2 write page0", 14'h07FF, 2'b01, 1'b1, 2'b00, 15'h2FFF);
      access("R2 exec page0",  14'h0000, 2'b10, 1'b1, 2'b00, 15'h2800);
   endtask

   task automatic t_perms;
      access("R6 ro read",     14'h0840, 2'b00, 1'b1, 2'b00, 15'h4840);
      access("R5 ro write",    14'h0840, 2'b01, 1'b0, 2'b11, 15'h0);
      access("R5 ro exec",     14'h0840, 2'b10, 1'b0, 2'b11, 15'h0);
      access("R6 xo exec",     14'h1010, 2'b10, 1'b1, 2'b00, 15'h1810);
      access("R6 xo read",     14'h1010, 2'b00, 1'b0, 2'b11, 15'h0);
      access("R6 xo write",    14'h1010, 2'b01, 1'b0, 2'b11, 15'h0);
      access("R5 no perm write", 14'h2000, 2'b01, 1'b0, 2'b11, 15'h0);
      access("R5 reserved kind", 14'h0001, 2'b11, 1'b0, 2'b11, 15'h0);
   endtask

   task automatic t_absent_and_len;
      access("R4 absent read",      14'h1800, 2'b00, 1'b0, 2'b10, 15'h0);
      access("R7 absent beats perm",14'h1805, 2'b01, 1'b0, 2'b10, 15'h0);
      access("R3 beyond length",    14'h3805, 2'b00, 1'b0, 2'b01, 15'h0);
      access("R7 length beats absent", 14'h2800, 2'b00, 1'b0, 2'b01, 15'h0);
      write_length(4'd8);
      access("R11 page7 at len8",   14'h3805, 2'b00, 1'b1, 2'b00, 15'h7805);
      access("R11 absent page5",    14'h2800, 2'b00, 1'b0, 2'b10, 15'h0);
   endtask

   task automatic t_done_pulse;
      access("R9 first", 14'h0004, 2'b00, 1'b1, 2'b00, 15'h2804);
      @(negedge clk);
      check("R9 done drops", {31'b0, rsp_done}, 32'd0);
      check("R9 result held", {17'b0, rsp_paddr}, 32'h2804);
      @(negedge clk);
      req_valid = 1'b1; req_addr = 14'h0008; req_kind = 2'b00;
      @(negedge clk);
      check("R9 back-to-back a", {17'b0, rsp_paddr}, 32'h2808);
      req_addr = 14'h0840;
      @(negedge clk);
      req_valid = 1'b0;
      check("R9 back-to-back b", {17'b0, rsp_paddr}, 32'h4840);
      check("R9 done b", {31'b0, rsp_done}, 32'd1);
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      cfg_we = 1'b1; cfg_len = 1'b0; cfg_idx = 3'd6; cfg_data = 8'hC4;
      req_valid = 1'b1; req_addr = 14'h3000; req_kind = 2'b00;
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
      check("R10 old contents cause", {30'b0, rsp_cause}, 32'd2);
      check("R10 old contents trap",  {31'b0, rsp_trap}, 32'd1);
      access("R10 new contents", 14'h3000, 2'b00, 1'b1, 2'b00, 15'h2000);
   endtask

   task automatic t_mid_reset;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check("R1 outputs cleared", {31'b0, rsp_ok}, 32'd0);
      access("R1 after second reset", 14'h0123, 2'b00, 1'b0, 2'b01, 15'h0);
      write_length(4'd8);
      access("R1 entries cleared", 14'h0123, 2'b00, 1'b0, 2'b10, 15'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_setup();
      t_translate();
      t_perms();
      t_absent_and_len();
      t_done_pulse();
      t_same_cycle();
      t_mid_reset();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule